// File: doc/BRIEF.md
# Indirect Configuration Access Translator

This block turns a single configuration request (target bus, device/function, register offset, access size, direction and write data) into the two accesses that a host bridge's indirect configuration port expects. First it writes a 32-bit address word into the port's address register. Then it performs the access through the port's data window, steering the data onto the proper byte lanes, and returns a completion status and, for reads, right-justified data.

A static quirk vector changes both phases. One flag adds the extended offset bits to the address word. Another marks requests to buses beyond the first as type 1. A third rejects everything except device/function 0 on the first bus, as on a bridge with no link. One flag presents the address word byte-reversed. Two flags patch write data: one clears the low byte of writes to the primary-bus register on the first bus, and the other zeroes writes to the cache-line-size register.

The control is a four-state machine. IDLE accepts a request (transition *accept*: IDLE to ADDR). In ADDR, a rejected request goes straight to RESP (*reject*), and otherwise the address write is offered until the port takes it (*addr_done*: ADDR to DATA). DATA offers the data-window access until the port takes it (*data_done*: DATA to RESP). RESP holds the response for one cycle and returns to IDLE (*retire*).

Top module: `cfg_indirect_xlate`

## Requirements
- R1: The address word has bit 31 set, the target bus number in bits 23:16, device/function in bits 15:8, offset bits 7:2 in bits 7:2, and bit 1 clear.
- R2: With quirk bit 0 (extended offsets) set, offset bits 11:8 appear in address bits 27:24. With it clear, address bits 30:24 are zero.
- R3: With quirk bit 1 (type marking) set and the target bus different from `cfg_first_bus`, address bit 0 is 1. In every other case it is 0.
- R4: When the target bus equals `cfg_first_bus`, bits 23:16 carry `cfg_self_bus`. Any other bus number is passed through unchanged.
- R5: With quirk bit 2 (no link) set, a request to a bus other than the first bus, or to any device/function other than 0, completes with `rsp_status`=1 and causes no port access.
- R6: The data access drives `port_be` with 1, 2 or 4 adjacent lanes (by `req_len`), starting at lane offset[1:0]. Write data is placed little-endian at that lane, and disabled lanes carry zero.
- R7: Read data is taken from the enabled lanes of `port_rdata`, shifted down to bit 0, and zero above the access size.
- R8: With quirk bit 3 (byte-reversed address) set, the address register write carries the address word with its four bytes in reverse order. Otherwise it carries the word as is. The address write always uses `port_be`=4'hF, `port_we`=1 and `port_sel`=0.
- R9: With quirk bit 4 set, a write to offset 0x018 on the first bus has bits 7:0 of its data forced to zero before lane steering. Writes to that offset on other buses are unchanged.
- R10: With quirk bit 5 set, a write to offset 0x00C sends all-zero data.
- R11: `req_ready` is high only in IDLE. Exactly one address write precedes exactly one data access per accepted request.
- R12: A request that is not rejected completes with `rsp_status`=0 after its data access. `rsp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_first_bus | input | 8 | Bus number of the bridge's own first bus |
| cfg_self_bus | input | 8 | Bus number placed in the address word for the first bus |
| cfg_quirks | input | 6 | Static quirk flags (bit meanings in R2, R3, R5, R8, R9, R10) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_off | input | 12 | Register offset in bytes |
| req_len | input | 3 | Access size in bytes: 1, 2 or 4 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 1 | 0 = success, 1 = device not found |
| rsp_rdata | output | 32 | Right-justified read data |
| port_valid | output | 1 | Port access offered |
| port_ready | input | 1 | Port access accepted |
| port_sel | output | 1 | 0 = address register, 1 = data window |
| port_we | output | 1 | Port access is a write |
| port_be | output | 4 | Port byte enables |
| port_wdata | output | 32 | Port write data |
| port_rdata | input | 32 | Port read data, valid in the data-phase handshake cycle |

## Verification
The assertions assume that requests carry a size of 1, 2 or 4 with an offset aligned to it, and that `cfg_quirks`, `cfg_first_bus` and `cfg_self_bus` stay constant while a request is in flight. They also assume that `port_rdata` is valid in the cycle the data access is taken. The stimulus draws a size first and then clears the low offset bits to match. It changes the configuration inputs only while the block is idle, between requests. Its responder returns read data derived from the last address word it accepted, so the data is stable throughout the data phase.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int QF_EXTREG = 0;
    localparam int QF_TYPE1  = 1;
    localparam int QF_NOLINK = 2;
    localparam int QF_BESWAP = 3;
    localparam int QF_PRISUP = 4;
    localparam int QF_CLZERO = 5;
    localparam int QUIRK_W   = 6;

    localparam logic [11:0] OFF_PRIBUS = 12'h018;
    localparam logic [11:0] OFF_CLSIZE = 12'h00C;

    localparam logic STAT_OK    = 1'b0;
    localparam logic STAT_NODEV = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_RESP = 2'd3
    } xl_state_t;
endpackage

// File: rtl/cfgx_addr_enc.sv
module cfgx_addr_enc
    import cfgx_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic [7:0]         bus,
    input  logic [7:0]         devfn,
    input  logic [11:0]        off,
    input  logic [QUIRK_W-1:0] quirks,
    input  logic [7:0]         first_bus,
    input  logic [7:0]         self_bus,
    output logic               on_first,
    output logic               reject,
    output logic [8*NBYTES-1:0] port_word
);
    localparam int WW = 8 * NBYTES;

    logic [WW-1:0] word;
    logic [WW-1:0] reversed;

    always_comb begin
        on_first   = (bus == first_bus);
        reject     = quirks[QF_NOLINK] && (!on_first || (devfn != 8'd0));
        word       = '0;
        word[31]   = 1'b1;
        word[23:16] = on_first ? self_bus : bus;
        word[15:8] = devfn;
        word[7:2]  = off[7:2];
        if (quirks[QF_EXTREG]) begin
            word[27:24] = off[11:8];
        end
        word[0] = quirks[QF_TYPE1] && !on_first;
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_rev
        assign reversed[8*g +: 8] = word[8*(NBYTES-1-g) +: 8];
    end

    assign port_word = quirks[QF_BESWAP] ? reversed : word;
endmodule

// File: rtl/cfgx_wpatch.sv
module cfgx_wpatch
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [11:0]        off,
    input  logic               on_first,
    input  logic [QUIRK_W-1:0] quirks,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  dout
);
    always_comb begin
        dout = din;
        if (quirks[QF_PRISUP] && on_first && (off == OFF_PRIBUS)) begin
            dout[7:0] = 8'h00;
        end
        if (quirks[QF_CLZERO] && (off == OFF_CLSIZE)) begin
            dout = '0;
        end
    end
endmodule

// File: rtl/cfgx_lane_steer.sv
module cfgx_lane_steer #(
    parameter int NBYTES = 4,
    localparam int DW    = 8 * NBYTES,
    localparam int OFS_W = $clog2(NBYTES),
    localparam int SH_W  = OFS_W + 3
) (
    input  logic [2:0]        len,
    input  logic [OFS_W-1:0]  boff,
    input  logic [DW-1:0]     wval,
    input  logic [DW-1:0]     raw_rd,
    output logic [NBYTES-1:0] be,
    output logic [DW-1:0]     lane_wdata,
    output logic [DW-1:0]     rdata_just
);
    logic [NBYTES-1:0] len_lanes;
    logic [DW-1:0]     dmask;
    logic [SH_W-1:0]   shamt;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign len_lanes[g]     = (32'(g) < 32'(len));
        assign dmask[8*g +: 8]  = {8{len_lanes[g]}};
    end

    assign shamt      = {boff, 3'b000};
    assign be         = len_lanes << boff;
    assign lane_wdata = (wval & dmask) << shamt;
    assign rdata_just = (raw_rd >> shamt) & dmask;
endmodule

// File: rtl/cfg_indirect_xlate.sv
module cfg_indirect_xlate
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         cfg_first_bus,
    input  logic [7:0]         cfg_self_bus,
    input  logic [QUIRK_W-1:0] cfg_quirks,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [7:0]         req_bus,
    input  logic [7:0]         req_devfn,
    input  logic [11:0]        req_off,
    input  logic [2:0]         req_len,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_status,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               port_valid,
    input  logic               port_ready,
    output logic               port_sel,
    output logic               port_we,
    output logic [NB-1:0]      port_be,
    output logic [DATA_W-1:0]  port_wdata,
    input  logic [DATA_W-1:0]  port_rdata
);
    xl_state_t state_q, state_d;

    logic [7:0]        bus_q, devfn_q;
    logic [11:0]       off_q;
    logic [2:0]        len_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic              status_q;
    logic [DATA_W-1:0] rdata_q;
    logic              addr_seen_q, data_seen_q;

    logic              on_first, rej;
    logic [DATA_W-1:0] addr_word, patched, lane_wd, rd_just;
    logic [NB-1:0]     lane_be;
    logic              port_fire;

    cfgx_addr_enc #(.NBYTES(NB)) u_enc (
        .bus(bus_q), .devfn(devfn_q), .off(off_q), .quirks(cfg_quirks),
        .first_bus(cfg_first_bus), .self_bus(cfg_self_bus),
        .on_first(on_first), .reject(rej), .port_word(addr_word)
    );

    cfgx_wpatch #(.DATA_W(DATA_W)) u_patch (
        .off(off_q), .on_first(on_first), .quirks(cfg_quirks),
        .din(wdata_q), .dout(patched)
    );

    cfgx_lane_steer #(.NBYTES(NB)) u_lane (
        .len(len_q), .boff(off_q[$clog2(NB)-1:0]), .wval(patched),
        .raw_rd(port_rdata), .be(lane_be), .lane_wdata(lane_wd),
        .rdata_just(rd_just)
    );

    assign port_fire = port_valid && port_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_ADDR;          // accept
            ST_ADDR: if (rej)        state_d = ST_RESP;          // reject
                     else if (port_ready) state_d = ST_DATA;     // addr_done
            ST_DATA: if (port_ready) state_d = ST_RESP;          // data_done
            ST_RESP:                 state_d = ST_IDLE;          // retire
            default:                 state_d = ST_IDLE;
        endcase
    end

    // request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0; devfn_q <= '0; off_q <= '0; len_q <= 3'd4;
            write_q <= 1'b0; wdata_q <= '0;
            status_q <= STAT_OK; rdata_q <= '0;
            addr_seen_q <= 1'b0; data_seen_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    addr_seen_q <= 1'b0;
                    data_seen_q <= 1'b0;
                    if (req_valid) begin
                        bus_q   <= req_bus;
                        devfn_q <= req_devfn;
                        off_q   <= req_off;
                        len_q   <= req_len;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        rdata_q <= '0;
                    end
                end
                ST_ADDR: begin
                    status_q <= rej ? STAT_NODEV : STAT_OK;
                    if (port_fire) addr_seen_q <= 1'b1;
                end
                ST_DATA: begin
                    if (port_fire) begin
                        data_seen_q <= 1'b1;
                        if (!write_q) rdata_q <= rd_just;
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        port_valid = 1'b0;
        port_sel   = 1'b0;
        port_we    = 1'b0;
        port_be    = '0;
        port_wdata = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ADDR: begin
                port_valid = !rej;
                port_we    = 1'b1;
                port_be    = '1;
                port_wdata = addr_word;
            end
            ST_DATA: begin
                port_valid = 1'b1;
                port_sel   = 1'b1;
                port_we    = write_q;
                port_be    = lane_be;
                port_wdata = write_q ? lane_wd : '0;
            end
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_status = status_q;
    assign rsp_rdata  = rdata_q;

    // R5: a rejected request never touched the port
    a_r5_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == STAT_NODEV) |-> (!addr_seen_q && !data_seen_q));

    // R6: data phase byte enables form a contiguous group of 1, 2 or 4 lanes
    a_r6_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && port_sel) |->
            (port_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111}));

    // R8: the address phase is a full-word write to the address register
    a_r8_addr_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && !port_sel) |-> (port_be == '1 && port_we));

    // R11: the data window is only used after the address write was taken
    a_r11_addr_before_data: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && port_sel) |-> addr_seen_q);

    // R11: an accepted request blocks the next one
    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R12: success is reported only after the data access
    a_r12_ok_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == STAT_OK) |-> data_seen_q);

    // R12: completion is a single-cycle pulse
    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/cfg_indirect_xlate_tb_top.sv
module cfg_indirect_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_first_bus = 8'h00;
    logic [7:0]  cfg_self_bus  = 8'h00;
    logic [5:0]  cfg_quirks    = 6'h00;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0, req_devfn = '0;
    logic [11:0] req_off = '0;
    logic [2:0]  req_len = 3'd4;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_status;
    logic [31:0] rsp_rdata;
    logic        port_valid, port_sel, port_we;
    logic        port_ready = 1'b0;
    logic [3:0]  port_be;
    logic [31:0] port_wdata, port_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int n_aw, n_dw, order_bad;
    logic [31:0] last_aw = '0, last_wd;
    logic [3:0]  last_be;
    logic        last_we;

    always #10 clk = ~clk;   // 50 MHz

    cfg_indirect_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_first_bus(cfg_first_bus), .cfg_self_bus(cfg_self_bus),
        .cfg_quirks(cfg_quirks),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
        .req_len(req_len), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .port_valid(port_valid), .port_ready(port_ready), .port_sel(port_sel),
        .port_we(port_we), .port_be(port_be), .port_wdata(port_wdata),
        .port_rdata(port_rdata)
    );

    function automatic logic [31:0] f_pattern(logic [31:0] w);
        return {w[15:0], w[31:16]} ^ 32'h6B2D_91E7;
    endfunction

    assign port_rdata = f_pattern(last_aw);

    // responder for the indirect port
    always @(negedge clk) port_ready <= port_valid && ($urandom_range(0, 2) != 0);

    always @(posedge clk) begin
        if (rst_n && port_valid && port_ready) begin
            if (!port_sel) begin
                n_aw++;
                last_aw = port_wdata;
                if (n_dw != 0) order_bad = 1;
            end else begin
                n_dw++;
                last_be = port_be;
                last_wd = port_wdata;
                last_we = port_we;
                if (n_aw == 0) order_bad = 1;
            end
        end
    end

    // reference model
    function automatic logic [31:0] f_addr(logic [7:0] b, logic [7:0] df,
                                           logic [11:0] o, logic [5:0] q,
                                           logic [7:0] fb, logic [7:0] sb);
        logic [31:0] w;
        w = 32'h8000_0000;
        w = w | ({24'd0, (b == fb) ? sb : b} << 16);
        w = w | ({24'd0, df} << 8);
        w = w | {24'd0, o[7:0] & 8'hFC};
        if (q[0]) w = w | ({28'd0, o[11:8]} << 24);
        if (q[1] && b != fb) w = w | 32'd1;
        if (q[3]) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
        return w;
    endfunction

    function automatic logic f_rej(logic [7:0] b, logic [7:0] df,
                                   logic [5:0] q, logic [7:0] fb);
        return q[2] && (b != fb || df != 8'd0);
    endfunction

    function automatic logic [31:0] f_mask(logic [2:0] l);
        return (l == 3'd1) ? 32'h0000_00FF : (l == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [3:0] f_be(logic [2:0] l, logic [1:0] bo);
        logic [3:0] m;
        m = (l == 3'd1) ? 4'b0001 : (l == 3'd2) ? 4'b0011 : 4'b1111;
        return m << bo;
    endfunction

    function automatic logic [31:0] f_patch(logic [31:0] v, logic [11:0] o,
                                            logic [7:0] b, logic [5:0] q,
                                            logic [7:0] fb);
        logic [31:0] r;
        r = v;
        if (q[4] && o == 12'h018 && b == fb) r = r & 32'hFFFF_FF00;
        if (q[5] && o == 12'h00C) r = 32'd0;
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_req(logic [7:0] b, logic [7:0] df, logic [11:0] o,
                          logic [2:0] l, logic we, logic [31:0] wd, logic [5:0] q);
        int guard;
        logic busy_ok;
        logic [31:0] ea;
        @(negedge clk);
        cfg_quirks = q;
        req_bus = b; req_devfn = df; req_off = o; req_len = l;
        req_write = we; req_wdata = wd; req_valid = 1'b1;
        n_aw = 0; n_dw = 0; order_bad = 0;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1;
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            guard++;
        end
        check("R11 ready low while busy", {31'd0, busy_ok}, 32'd1);
        check("R12 response pulse", {31'd0, rsp_valid}, 32'd1);
        if (f_rej(b, df, q, cfg_first_bus)) begin
            check("R5 status not found", {31'd0, rsp_status}, 32'd1);
            check("R5 no port access", n_aw + n_dw, 32'd0);
        end else begin
            ea = f_addr(b, df, o, q, cfg_first_bus, cfg_self_bus);
            check("R12 status ok", {31'd0, rsp_status}, 32'd0);
            check("R11 one address write", n_aw, 32'd1);
            check("R11 one data access", n_dw, 32'd1);
            check("R11 order", order_bad, 32'd0);
            check("R1 R2 R3 R4 R8 address word", last_aw, ea);
            check("R6 byte enables", {28'd0, last_be}, {28'd0, f_be(l, o[1:0])});
            check("R6 direction", {31'd0, last_we}, {31'd0, we});
            if (we) begin
                check("R6 R9 R10 lane data", last_wd,
                      (f_patch(wd, o, b, q, cfg_first_bus) & f_mask(l)) << (8 * o[1:0]));
            end else begin
                check("R7 read data", rsp_rdata,
                      (f_pattern(ea) >> (8 * o[1:0])) & f_mask(l));
            end
        end
        @(negedge clk);
        check("R12 pulse ends", {31'd0, rsp_valid}, 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2:0]  l;
        logic [11:0] o;
        logic [7:0]  b, df;
        void'($urandom(32'd1207));
        cfg_first_bus = 8'h00;
        cfg_self_bus  = 8'h00;
        repeat (3) @(negedge clk);
        check("R11 reset ready", {31'd0, req_ready}, 32'd1);
        check("R12 reset no response", {31'd0, rsp_valid}, 32'd0);
        check("R11 reset port idle", {31'd0, port_valid}, 32'd0);
        rst_n = 1'b1;

        // directed corners
        do_req(8'h00, 8'h00, 12'h010, 3'd4, 1'b0, 32'd0, 6'h00);          // R1
        do_req(8'h03, 8'h21, 12'hA48, 3'd4, 1'b0, 32'd0, 6'h01);          // R2
        do_req(8'h03, 8'h21, 12'hA48, 3'd4, 1'b0, 32'd0, 6'h00);          // R2 clear
        do_req(8'h05, 8'h08, 12'h004, 3'd2, 1'b0, 32'd0, 6'h02);          // R3
        do_req(8'h00, 8'h08, 12'h004, 3'd2, 1'b0, 32'd0, 6'h02);          // R3 first bus
        @(negedge clk); cfg_first_bus = 8'h04; cfg_self_bus = 8'h00;
        do_req(8'h04, 8'h10, 12'h000, 3'd4, 1'b0, 32'd0, 6'h00);          // R4 substitute
        do_req(8'h09, 8'h10, 12'h000, 3'd4, 1'b0, 32'd0, 6'h00);          // R4 passthrough
        do_req(8'h09, 8'h00, 12'h000, 3'd4, 1'b0, 32'd0, 6'h04);          // R5 other bus
        do_req(8'h04, 8'h01, 12'h000, 3'd4, 1'b1, 32'h1234, 6'h04);       // R5 devfn
        do_req(8'h04, 8'h00, 12'h008, 3'd4, 1'b0, 32'd0, 6'h04);          // R5 allowed
        do_req(8'h04, 8'h00, 12'h003, 3'd1, 1'b1, 32'h0000_00A5, 6'h00);  // R6 lane 3
        do_req(8'h04, 8'h00, 12'h002, 3'd2, 1'b0, 32'd0, 6'h00);          // R7 upper half
        do_req(8'h04, 8'h00, 12'h001, 3'd1, 1'b0, 32'd0, 6'h00);          // R7 byte
        do_req(8'h07, 8'h33, 12'h1F4, 3'd4, 1'b0, 32'd0, 6'h0B);          // R8 reversed
        do_req(8'h04, 8'h00, 12'h018, 3'd4, 1'b1, 32'h00AB_CDEF, 6'h10);  // R9 first bus
        do_req(8'h06, 8'h00, 12'h018, 3'd4, 1'b1, 32'h00AB_CDEF, 6'h10);  // R9 other bus
        do_req(8'h04, 8'h00, 12'h018, 3'd1, 1'b1, 32'h0000_0077, 6'h10);  // R9 byte write
        do_req(8'h06, 8'h00, 12'h00C, 3'd1, 1'b1, 32'h0000_0040, 6'h20);  // R10
        do_req(8'h06, 8'h00, 12'h00C, 3'd1, 1'b1, 32'h0000_0040, 6'h00);  // R10 clear

        // constrained random
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ((i % 50) == 0) begin
                cfg_first_bus = 8'($urandom_range(0, 3));
                cfg_self_bus  = 8'($urandom);
            end
            case ($urandom_range(0, 2))
                0: l = 3'd1;
                1: l = 3'd2;
                default: l = 3'd4;
            endcase
            o = 12'($urandom);
            case ($urandom_range(0, 7))
                0: o = 12'h018;
                1: o = 12'h00C;
                default: ;
            endcase
            if (l == 3'd2) o[0] = 1'b0;
            if (l == 3'd4) o[1:0] = 2'b00;
            b  = ($urandom_range(0, 1) == 0) ? cfg_first_bus : 8'($urandom_range(0, 7));
            df = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
            do_req(b, df, o, l, 1'($urandom), $urandom, 6'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule